// File: doc/BRIEF.md
# Attention Byte Sender for an Open-Collector Serial Bus

This block places one command byte on a three-wire open-collector serial bus while the attention line is held low, so that every attached peripheral receives it. On a start strobe it pulls attention low and releases clock and data. After a short delay it also pulls clock low. It then waits for at least one peripheral to answer by pulling data low. After a settling interval it releases clock and waits for every listener to release data. It then shifts the eight bits out least significant bit first and finally waits for a frame acknowledge on data.

For command bytes in the talk and listen range, and when the caller enables it, the block can also ask the listener whether it supports a faster transfer protocol. It does this through a timing side channel: clock is held low for a much longer gap just before the last bit, with data released. A listener that supports the faster protocol answers with a short low pulse on data inside that gap, and the block records the answer. Every delay counts a one-microsecond tick input, and the clock and data lines are synchronised before use. The outputs are active-high pull-low enables, one per line. The caller reads the result flags once `done` rises.

Top module: `atn_byte_sender`

## Requirements
- R1: After reset all three pull enables, `busy`, `done` and the three result flags are 0.
- R2: A start strobe makes `atn_pull` 1 and `clk_pull`/`data_pull` 0 with `busy` 1 on the next cycle; `clk_pull` rises no earlier than T_AC ticks later.
- R3: If data is not seen low within T_AT ticks of attention being asserted, the block finishes with `done` 1 and `err_absent` 1, and sends no bits.
- R4: Once a peripheral has pulled data low, clock stays pulled for at least T_AL ticks before it is released.
- R5: With clock released, the block waits for data to be seen high; if it stays low for T_HA ticks, the block finishes with `err_timeout` 1.
- R6: The eight bits go out least significant first. For each bit clock is pulled for T_ST ticks and then released for T_VT ticks, with data pulled for a 0 bit and released for a 1 bit; a listener samples the bit when clock is released.
- R7: After the last bit, clock is pulled and data released. If data is seen low within T_F ticks, the block finishes with no error flag; otherwise it finishes with `err_timeout` 1.
- R8: Only when `solicit_en` is 1 at start and the byte lies in 0x20..0x5F does clock stay low for at least T_JD+T_ST ticks before bit 7, with data released for the first T_JD; otherwise bit 7's clock-low phase is shorter than T_JD.
- R9: A data low pulse of one clock cycle or longer inside the solicitation gap sets `fast_ok` to 1 at the finish; with no pulse, or with no gap, `fast_ok` is 0.
- R10: On finishing, `atn_pull` and `clk_pull` are 1, `data_pull` is 0, `busy` is 0 and `done` is 1. These outputs and the result flags hold until the next start.
- R11: A start strobe during a transfer abandons it at once: on the next cycle clock and data are released, `done` is 0, and the sequence restarts from R2 with the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond; all delays count it |
| start | input | 1 | Start (or restart) a transfer |
| tx_byte | input | 8 | Byte to send, captured at start |
| solicit_en | input | 1 | Allow the fast-protocol solicitation, captured at start |
| clk_in | input | 1 | Sampled bus clock level (1 = released/high) |
| data_in | input | 1 | Sampled bus data level (1 = released/high) |
| atn_pull | output | 1 | 1 pulls the attention line low |
| clk_pull | output | 1 | 1 pulls the clock line low |
| data_pull | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished; results valid |
| err_absent | output | 1 | No peripheral answered attention |
| err_timeout | output | 1 | Listener hold-off or frame acknowledge timed out |
| fast_ok | output | 1 | Listener accepted the fast protocol |

## Verification
The bench builds the block with a tick on every clock and shrinks the delays to a few ticks: T_AC=3, T_AT=12, T_AL=6, T_HA=40, T_ST=4, T_VT=3, T_F=10, T_JD=16. With these values a transfer takes little more than a hundred cycles. That makes it possible to send all 256 byte values with solicitation enabled, answering the gap on alternating pairs with pulses of one to four cycles, and then a strided set with solicitation off. The same small delays let the bench measure every clock phase against its limit. They also bring the absent-device, hold-off, missing-acknowledge and mid-transfer restart cases within a short run.

// File: rtl/atx_pkg.sv
package atx_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ALERT,
      S_PRESENCE,
      S_SETTLE_AL,
      S_READY,
      S_BIT_LOW,
      S_BIT_HIGH,
      S_GAP,
      S_ACK,
      S_FINISH
   } atx_state_e;

   function automatic int atx_max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/atx_sync.sv
module atx_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= '1;
      else        st[0] <= d;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[g] <= '1;
         else        st[g] <= st[g-1];
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/atx_tick_timer.sv
module atx_tick_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] CNT_TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (clr)                       cnt <= '0;
      else if (tick && (cnt != CNT_TOP))  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/atn_byte_sender.sv
module atn_byte_sender
   import atx_pkg::*;
#(
   parameter int          SYNC_STAGES     = 2,
   parameter bit          SOLICIT_SUPPORT = 1'b1,
   parameter logic [7:0]  RANGE_LO        = 8'h20,
   parameter logic [7:0]  RANGE_HI        = 8'h5F,
   parameter int          T_AC            = 20,
   parameter int          T_AT            = 1000,
   parameter int          T_AL            = 1000,
   parameter int          T_HA            = 64000,
   parameter int          T_ST            = 35,
   parameter int          T_VT            = 35,
   parameter int          T_F             = 1000,
   parameter int          T_JD            = 320
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       us_tick,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       solicit_en,
   input  logic       clk_in,
   input  logic       data_in,
   output logic       atn_pull,
   output logic       clk_pull,
   output logic       data_pull,
   output logic       busy,
   output logic       done,
   output logic       err_absent,
   output logic       err_timeout,
   output logic       fast_ok
);

   localparam int T_MAX  = atx_max2(atx_max2(atx_max2(T_AC, T_AT), atx_max2(T_AL, T_HA)),
                                    atx_max2(atx_max2(T_ST, T_VT), atx_max2(T_F, T_JD)));
   localparam int TW     = $clog2(T_MAX + 1);
   localparam int SETTLE = SYNC_STAGES + 1;
   localparam int SW     = $clog2(SETTLE + 1);
   localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (T_AT <= T_AC) begin : g_bad_at
      $error("T_AT must exceed T_AC");
   end
   if (T_JD <= T_ST) begin : g_bad_jd
      $error("T_JD must exceed T_ST");
   end
   if (RANGE_LO > RANGE_HI) begin : g_bad_range
      $error("RANGE_LO must not exceed RANGE_HI");
   end

   atx_state_e        state, state_nxt;
   logic [7:0]        byte_q;
   logic              sol_q;
   logic [2:0]        idx;
   logic [TW-1:0]     cnt;
   logic [SW-1:0]     settle;
   logic              look, chg, clr;
   logic              set_absent, set_tmo;
   logic              clk_s, data_s;
   logic              sol_ok;

   atx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({clk_in, data_in}),
      .q     ({clk_s, data_s})
   );

   atx_tick_timer #(.W(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .tick  (us_tick),
      .cnt   (cnt)
   );

   if (SOLICIT_SUPPORT) begin : g_sol
      assign sol_ok = solicit_en && (tx_byte >= RANGE_LO) && (tx_byte <= RANGE_HI);
   end else begin : g_nosol
      assign sol_ok = 1'b0;
   end

   always_comb begin
      state_nxt  = state;
      set_absent = 1'b0;
      set_tmo    = 1'b0;
      if (start) begin
         state_nxt = S_ALERT;
      end else begin
         unique case (state)
            S_ALERT: begin
               if (cnt >= TW'(T_AC)) state_nxt = S_PRESENCE;
            end
            S_PRESENCE: begin
               if (look && !data_s) begin
                  state_nxt = S_SETTLE_AL;
               end else if (cnt >= TW'(T_AT)) begin
                  state_nxt  = S_FINISH;
                  set_absent = 1'b1;
               end
            end
            S_SETTLE_AL: begin
               if (cnt >= TW'(T_AL)) state_nxt = S_READY;
            end
            S_READY: begin
               if (look && data_s && clk_s) begin
                  state_nxt = S_BIT_LOW;
               end else if (cnt >= TW'(T_HA)) begin
                  state_nxt = S_FINISH;
                  set_tmo   = 1'b1;
               end
            end
            S_BIT_LOW: begin
               if (cnt >= TW'(T_ST)) state_nxt = S_BIT_HIGH;
            end
            S_BIT_HIGH: begin
               if (cnt >= TW'(T_VT)) begin
                  if (idx == 3'd7)               state_nxt = S_ACK;
                  else if (idx == 3'd6 && sol_q) state_nxt = S_GAP;
                  else                           state_nxt = S_BIT_LOW;
               end
            end
            S_GAP: begin
               if (cnt >= TW'(T_JD)) state_nxt = S_BIT_LOW;
            end
            S_ACK: begin
               if (look && !data_s) begin
                  state_nxt = S_FINISH;
               end else if (cnt >= TW'(T_F)) begin
                  state_nxt = S_FINISH;
                  set_tmo   = 1'b1;
               end
            end
            default: state_nxt = state;
         endcase
      end
   end

   assign chg  = start || (state_nxt != state);
   assign clr  = chg && !(!start && state == S_ALERT && state_nxt == S_PRESENCE);
   assign look = (settle == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              settle <= SETTLE_V;
      else if (chg)            settle <= SETTLE_V;
      else if (settle != '0)   settle <= settle - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         byte_q      <= '0;
         sol_q       <= 1'b0;
         idx         <= '0;
         err_absent  <= 1'b0;
         err_timeout <= 1'b0;
         fast_ok     <= 1'b0;
         done        <= 1'b0;
      end else begin
         state <= state_nxt;
         if (start) begin
            byte_q      <= tx_byte;
            sol_q       <= sol_ok;
            idx         <= '0;
            err_absent  <= 1'b0;
            err_timeout <= 1'b0;
            fast_ok     <= 1'b0;
            done        <= 1'b0;
         end else begin
            if (state == S_GAP && look && !data_s)
               fast_ok <= 1'b1;
            if (state == S_BIT_HIGH && state_nxt != S_BIT_HIGH && idx != 3'd7)
               idx <= idx + 1'b1;
            if (state_nxt == S_FINISH && state != S_FINISH) begin
               done        <= 1'b1;
               err_absent  <= set_absent;
               err_timeout <= set_tmo;
            end
         end
      end
   end

   assign atn_pull  = (state != S_IDLE);
   assign clk_pull  = (state == S_PRESENCE) || (state == S_SETTLE_AL) ||
                      (state == S_BIT_LOW)  || (state == S_GAP)       ||
                      (state == S_ACK)      || (state == S_FINISH);
   assign data_pull = ((state == S_BIT_LOW) || (state == S_BIT_HIGH)) && !byte_q[idx];
   assign busy      = (state != S_IDLE) && (state != S_FINISH);

endmodule

// File: rtl/atn_byte_sender_chk.sv
module atn_byte_sender_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic atn_pull,
   input logic clk_pull,
   input logic data_pull,
   input logic busy,
   input logic done,
   input logic err_absent,
   input logic err_timeout,
   input logic fast_ok,
   input logic sol_q
);

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done) |-> (!atn_pull && !clk_pull && !data_pull)); // R1

   AST_BUSY_HOLDS_ATN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> atn_pull); // R2

   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !done && !clk_pull && !data_pull)); // R11

   AST_FINISH_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (atn_pull && clk_pull && !data_pull && !busy)); // R10

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable({err_absent, err_timeout, fast_ok}))); // R10

   AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({err_absent, err_timeout}) <= 1); // R7

   AST_ABSENT_NO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      err_absent |-> !fast_ok); // R3

   AST_FAST_ONLY_SOLICITED: assert property (@(posedge clk) disable iff (!rst_n)
      fast_ok |-> sol_q); // R8

endmodule

bind atn_byte_sender atn_byte_sender_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .atn_pull    (atn_pull),
   .clk_pull    (clk_pull),
   .data_pull   (data_pull),
   .busy        (busy),
   .done        (done),
   .err_absent  (err_absent),
   .err_timeout (err_timeout),
   .fast_ok     (fast_ok),
   .sol_q       (sol_q)
);

// File: tb/atn_byte_sender_test.sv
module atn_byte_sender_test;

   localparam int AC = 3;
   localparam int AT = 12;
   localparam int AL = 6;
   localparam int HA = 40;
   localparam int ST = 4;
   localparam int VT = 3;
   localparam int F  = 10;
   localparam int JD = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       us_tick = 1'b1;
   logic       start = 1'b0;
   logic [7:0] tx_byte = '0;
   logic       solicit_en = 1'b0;
   logic       clk_in, data_in;
   logic       atn_pull, clk_pull, data_pull, busy, done;
   logic       err_absent, err_timeout, fast_ok;
   logic       p_data = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   assign clk_in  = !clk_pull;
   assign data_in = !(data_pull || p_data);

   atn_byte_sender #(
      .T_AC(AC), .T_AT(AT), .T_AL(AL), .T_HA(HA),
      .T_ST(ST), .T_VT(VT), .T_F(F), .T_JD(JD)
   ) uut (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
      .tx_byte(tx_byte), .solicit_en(solicit_en),
      .clk_in(clk_in), .data_in(data_in),
      .atn_pull(atn_pull), .clk_pull(clk_pull), .data_pull(data_pull),
      .busy(busy), .done(done), .err_absent(err_absent),
      .err_timeout(err_timeout), .fast_ok(fast_ok)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc >= 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_start(input logic [7:0] b, input bit sol);
      @(negedge clk);
      tx_byte    = b;
      solicit_en = sol;
      start      = 1'b1;
      @(negedge clk);
      start      = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] b, input bit sol, input bit jd, input int pw, input bit ack);
      logic [7:0] got;
      int         len;
      bit         gap_exp;
      bit         fast_exp;
      gap_exp  = sol && (b >= 8'h20) && (b <= 8'h5F);
      fast_exp = gap_exp && jd;
      got      = '0;
      do_start(b, sol);
      check(atn_pull && !clk_pull && !data_pull && busy && !done, "R2 start lines",
            {atn_pull, clk_pull, data_pull, busy, done}, 5'b10010);
      len = 0;
      while (!clk_pull) begin @(negedge clk); len++; end
      check(len >= AC, "R2 attention-to-clock delay", len, AC);
      p_data = 1'b1;
      len = 0;
      while (clk_pull) begin @(negedge clk); len++; end
      check(len >= AL, "R4 clock hold after response", len, AL);
      repeat (5) @(negedge clk);
      p_data = 1'b0;
      for (int i = 0; i < 8; i++) begin
         while (clk_in) @(negedge clk);
         len = 0;
         while (!clk_in) begin
            if (jd && i == 7 && len == 8) p_data = 1'b1;
            if (len == 8 + pw) p_data = 1'b0;
            @(negedge clk);
            len++;
         end
         p_data = 1'b0;
         got[i] = data_in;
         if (i == 7) begin
            if (gap_exp) check(len >= JD + ST, "R8 solicitation gap length", len, JD + ST);
            else         check(len < JD, "R8 no gap outside range or disabled", len, JD);
         end
      end
      check(got == b, "R6 byte on bus", got, b);
      while (clk_in) @(negedge clk);
      if (ack) begin
         repeat (2) @(negedge clk);
         p_data = 1'b1;
      end
      while (!done) @(negedge clk);
      if (ack) begin
         check(!err_absent && !err_timeout, "R7 acknowledged finish", {err_absent, err_timeout}, 0);
         check(fast_ok == fast_exp, "R9 fast protocol result", fast_ok, fast_exp);
      end else begin
         check(err_timeout && !err_absent, "R7 missing acknowledge", {err_absent, err_timeout}, 1);
      end
      check(atn_pull && clk_pull && !data_pull && !busy, "R10 finish lines",
            {atn_pull, clk_pull, data_pull, busy}, 4'b1100);
      p_data = 1'b0;
      repeat (3) @(negedge clk);
      check(done && atn_pull && clk_pull, "R10 finish holds", {done, atn_pull, clk_pull}, 3'b111);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check({atn_pull, clk_pull, data_pull, busy, done, err_absent, err_timeout, fast_ok} == 8'h00,
            "R1 reset state", {atn_pull, clk_pull, data_pull, busy, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!atn_pull && !busy && !done, "R1 idle after reset", {atn_pull, busy, done}, 0);

      // R3: nobody answers attention
      do_start(8'h28, 1'b1);
      n = 1;
      while (!done) begin @(negedge clk); n++; end
      check(err_absent && !err_timeout && !fast_ok, "R3 device not present",
            {err_absent, err_timeout, fast_ok}, 3'b100);
      check(n >= AT, "R3 presence window", n, AT);

      // R5: listener never releases data
      do_start(8'h3F, 1'b0);
      p_data = 1'b1;
      while (!clk_pull) @(negedge clk);
      while (clk_pull) @(negedge clk);
      n = 0;
      while (!done) begin @(negedge clk); n++; end
      check(err_timeout && !err_absent, "R5 hold-off timeout", {err_absent, err_timeout}, 1);
      check(n >= HA, "R5 hold-off window", n, HA);
      p_data = 1'b0;

      // R11: restart during the clock hold after response
      do_start(8'h28, 1'b1);
      p_data = 1'b1;
      while (!clk_pull) @(negedge clk);
      repeat (3) @(negedge clk);
      @(negedge clk);
      tx_byte = 8'h41; solicit_en = 1'b0; start = 1'b1; p_data = 1'b0;
      @(negedge clk);
      start = 1'b0;
      check(!clk_pull && !data_pull && busy && !done && atn_pull, "R11 restart releases lines",
            {clk_pull, data_pull, busy, done}, 4'b0010);
      while (!done) @(negedge clk);
      check(err_absent, "R11 restarted sequence", err_absent, 1);

      // R7: no frame acknowledge
      xfer(8'hA5, 1'b0, 1'b0, 1, 1'b0);
      xfer(8'h44, 1'b1, 1'b1, 2, 1'b0);

      // R6 R8 R9: full sweep with solicitation on
      for (int b = 0; b < 256; b++) xfer(8'(b), 1'b1, b[1], 1 + (b % 4), 1'b1);
      // R8 R9: solicitation off, device would answer
      for (int b = 0; b < 256; b += 5) xfer(8'(b), 1'b0, 1'b1, 2, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule